// File: doc/BRIEF.md
# Overlapping Serial Pattern Detector

This block watches a one-bit serial stream, taking one bit per clock when a valid qualifier is high, and pulses a match flag in the same cycle that the last bit of the pattern 1101 arrives. Matches may overlap. The trailing 1 of one match can serve as the leading 1 of the next, so the stream 1101101 gives two matches.

The detector is a four-state Mealy machine. Each state records the longest prefix of the pattern that the recent bits end with: none, "1", "11" or "110". The match flag comes combinationally from the registered state and the present bit, so there is no output register. An elaboration parameter selects how the state is stored, either as a dense two-bit binary code or as a four-bit one-hot vector. The observable behaviour is the same for both.

Top module: `serial_pattern_watch`

## Requirements
- R1: While `rst` is high on a rising edge, the machine returns to the empty-prefix state, and `match_pulse` is 0 for as long as `rst` is high. After reset, the bits 1,0,1 alone do not produce a match.
- R2: From the empty-prefix state, an accepted 0 keeps the machine in that state and an accepted 1 moves it to the "1" state. Neither bit raises `match_pulse`.
- R3: From the "1" state, an accepted 0 returns the machine to the empty-prefix state and an accepted 1 moves it to the "11" state.
- R4: From the "11" state, an accepted 0 moves the machine to the "110" state and an accepted 1 keeps it in the "11" state. The stream 1,1,1,1,0,1 therefore matches on its last bit only.
- R5: From the "110" state, an accepted 0 returns the machine to the empty-prefix state and does not raise `match_pulse`.
- R6: From the "110" state, an accepted 1 raises `match_pulse` in that same cycle, before the clock edge, and moves the machine to the "1" state.
- R7: `match_pulse` is 1 only when the machine is in the "110" state, `bit_valid` is 1, `bit_in` is 1 and `rst` is 0. It is never held high for two cycles in a row.
- R8: While `bit_valid` is 0, the state is held and `match_pulse` is 0, whatever the value on `bit_in`.
- R9: For the accepted stream 1101101, `match_pulse` is high at bit positions 4 and 7, counting the first bit as position 1, and low at every other position.
- R10: With `STATE_ONEHOT` = 0 the state is held in two binary-coded flops; with `STATE_ONEHOT` = 1 it is held in four one-hot flops. Both variants give identical `match_pulse` sequences.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | High when `bit_in` carries a bit to be taken this cycle |
| bit_in | input | 1 | Serial data bit |
| match_pulse | output | 1 | Combinational Mealy output: high in the cycle that completes 1101 |

## Verification
The properties assume that `bit_valid`, `bit_in` and `rst` are driven to known values before each rising edge and stay stable across it. The transition properties also treat a cycle with `rst` high as a restart rather than a step of the pattern. The stimulus meets these assumptions by driving inputs only on the falling edge and by pulsing reset between scenarios. Two instances, one per state encoding, receive the same stream, so the encoding variants are compared cycle by cycle against expected values that come from the pattern alone.

// File: rtl/spw_pkg.sv
package spw_pkg;
   // Longest pattern prefix that the accepted bits currently end with.
   typedef enum logic [1:0] {
      PS_NONE  = 2'd0,
      PS_ONE   = 2'd1,
      PS_ONE2  = 2'd2,
      PS_ONE2Z = 2'd3
   } prefix_e;

   localparam int unsigned NUM_PREFIX = 4;
endpackage

// File: rtl/spw_next.sv
module spw_next
   import spw_pkg::*;
(
   input  prefix_e cur,
   input  logic    bit_valid,
   input  logic    bit_in,
   output prefix_e nxt,
   output logic    hit
);
   prefix_e step;

   always_comb begin
      unique case (cur)
         PS_NONE:  step = bit_in ? PS_ONE  : PS_NONE;
         PS_ONE:   step = bit_in ? PS_ONE2 : PS_NONE;
         PS_ONE2:  step = bit_in ? PS_ONE2 : PS_ONE2Z;
         PS_ONE2Z: step = bit_in ? PS_ONE  : PS_NONE;
         default:  step = PS_NONE;
      endcase
   end

   assign nxt = bit_valid ? step : cur;
   assign hit = bit_valid && bit_in && (cur == PS_ONE2Z);
endmodule

// File: rtl/spw_state_reg.sv
module spw_state_reg
   import spw_pkg::*;
#(
   parameter bit STATE_ONEHOT = 1'b0
) (
   input  logic    clk,
   input  logic    rst,
   input  prefix_e nxt,
   output prefix_e cur
);
   localparam int unsigned SW = STATE_ONEHOT ? NUM_PREFIX : $clog2(NUM_PREFIX);

   if (NUM_PREFIX != 4) begin : g_bad_count
      $error("spw_state_reg: prefix count must be four");
   end

   if (STATE_ONEHOT) begin : g_onehot
      logic [SW-1:0] oh_q;
      always_ff @(posedge clk) begin
         if (rst) oh_q <= SW'(1);
         else     oh_q <= SW'(1) << nxt;
      end
      always_comb begin
         cur = PS_NONE;
         for (int k = 0; k < NUM_PREFIX; k++) begin
            if (oh_q[k]) cur = prefix_e'(k[1:0]);
         end
      end
   end else begin : g_binary
      logic [SW-1:0] bin_q;
      always_ff @(posedge clk) begin
         if (rst) bin_q <= SW'(PS_NONE);
         else     bin_q <= SW'(nxt);
      end
      assign cur = prefix_e'(bin_q);
   end
endmodule

// File: rtl/serial_pattern_watch.sv
module serial_pattern_watch
   import spw_pkg::*;
#(
   parameter bit STATE_ONEHOT = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic bit_valid,
   input  logic bit_in,
   output logic match_pulse
);
   prefix_e cur_st;
   prefix_e nxt_st;
   logic    hit;

   spw_next u_next (
      .cur       (cur_st),
      .bit_valid (bit_valid),
      .bit_in    (bit_in),
      .nxt       (nxt_st),
      .hit       (hit)
   );

   spw_state_reg #(.STATE_ONEHOT(STATE_ONEHOT)) u_reg (
      .clk (clk),
      .rst (rst),
      .nxt (nxt_st),
      .cur (cur_st)
   );

   assign match_pulse = hit && !rst;
endmodule

// File: rtl/spw_checker.sv
module spw_checker
   import spw_pkg::*;
(
   input logic    clk,
   input logic    rst,
   input logic    bit_valid,
   input logic    bit_in,
   input logic    match_pulse,
   input prefix_e cur
);
   p_reset_idle_r1: assert property (@(posedge clk) rst |=> cur == PS_NONE);

   p_none_step_r2: assert property (@(posedge clk) disable iff (rst)
      (bit_valid && cur == PS_NONE) |=> cur == (($past(bit_in)) ? PS_ONE : PS_NONE));

   p_one_step_r3: assert property (@(posedge clk) disable iff (rst)
      (bit_valid && cur == PS_ONE) |=> cur == (($past(bit_in)) ? PS_ONE2 : PS_NONE));

   p_one2_step_r4: assert property (@(posedge clk) disable iff (rst)
      (bit_valid && cur == PS_ONE2) |=> cur == (($past(bit_in)) ? PS_ONE2 : PS_ONE2Z));

   p_drop_on_zero_r5: assert property (@(posedge clk) disable iff (rst)
      (bit_valid && !bit_in && cur == PS_ONE2Z) |=> cur == PS_NONE);

   p_after_match_r6: assert property (@(posedge clk) disable iff (rst)
      match_pulse |=> cur == PS_ONE);

   p_no_double_r7: assert property (@(posedge clk) disable iff (rst)
      match_pulse |=> !match_pulse);

   p_match_qualified_r7: assert property (@(posedge clk)
      match_pulse |-> (bit_valid && !rst && cur == PS_ONE2Z));

   p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
      !bit_valid |=> $stable(cur));
endmodule

bind serial_pattern_watch spw_checker u_chk (
   .clk         (clk),
   .rst         (rst),
   .bit_valid   (bit_valid),
   .bit_in      (bit_in),
   .match_pulse (match_pulse),
   .cur         (cur_st)
);

// File: tb/serial_pattern_watch_tb.sv
module serial_pattern_watch_tb;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic bit_valid = 1'b0;
   logic bit_in = 1'b0;
   logic m_bin, m_oh;
   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   always #4 clk = ~clk;

   serial_pattern_watch #(.STATE_ONEHOT(1'b0)) u_dut (
      .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in), .match_pulse(m_bin));
   serial_pattern_watch #(.STATE_ONEHOT(1'b1)) u_dut_oh (
      .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in), .match_pulse(m_oh));

   task automatic check(input string req, input logic exp);
      n_chk++;
      if (m_bin !== exp) begin
         n_fail++;
         $display("FAIL %s binary: match_pulse=%b expected=%b", req, m_bin, exp);
      end
      n_chk++;
      if (m_oh !== exp) begin
         n_fail++;
         $display("FAIL %s onehot R10: match_pulse=%b expected=%b", req, m_oh, exp);
      end
   endtask

   // Drive at the falling edge, check before the rising edge, then let it clock.
   task automatic step(input logic v, input logic b, input logic exp, input string req);
      @(negedge clk);
      rst = 1'b0; bit_valid = v; bit_in = b;
      #2 check(req, exp);
   endtask

   task automatic pulse_reset();
      @(negedge clk);
      rst = 1'b1; bit_valid = 1'b1; bit_in = 1'b1;
      #2 check("R1", 1'b0);
      @(negedge clk);
      rst = 1'b1;
   endtask

   // Accepted bits are applied left to right: bit i = bits[n-1-i].
   task automatic run(input logic [15:0] bits, input logic [15:0] exp, input int n,
                      input string req);
      for (int i = n - 1; i >= 0; i--) step(1'b1, bits[i], exp[i], req);
   endtask

   task automatic t_reset_r1();
      pulse_reset();
      run(16'b110, 16'b000, 3, "R1");
      pulse_reset();
      run(16'b101, 16'b000, 3, "R1");
   endtask

   task automatic t_none_r2();
      pulse_reset();
      run(16'b0001101, 16'b0000001, 7, "R2");
   endtask

   task automatic t_one_r3();
      pulse_reset();
      run(16'b1010101, 16'b0000000, 7, "R3");
      run(16'b101, 16'b001, 3, "R3");
   endtask

   task automatic t_one2_r4();
      pulse_reset();
      run(16'b111101, 16'b000001, 6, "R4");
   endtask

   task automatic t_drop_r5();
      pulse_reset();
      run(16'b11001101, 16'b00000001, 8, "R5");
   endtask

   task automatic t_match_r6();
      pulse_reset();
      run(16'b1101, 16'b0001, 4, "R6");
      run(16'b101, 16'b001, 3, "R6");
   endtask

   task automatic t_overlap_r9();
      pulse_reset();
      run(16'b1101101, 16'b0001001, 7, "R9");
      run(16'b101101, 16'b001001, 6, "R9");
   endtask

   task automatic t_valid_r8();
      pulse_reset();
      run(16'b110, 16'b000, 3, "R8");
      step(1'b0, 1'b1, 1'b0, "R8");
      step(1'b0, 1'b0, 1'b0, "R8");
      step(1'b0, 1'b1, 1'b0, "R8");
      step(1'b1, 1'b1, 1'b1, "R8");
      step(1'b0, 1'b1, 1'b0, "R7");
      step(1'b1, 1'b0, 1'b0, "R7");
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (2) @(posedge clk);
      t_reset_r1();
      t_none_r2();
      t_one_r3();
      t_one2_r4();
      t_drop_r5();
      t_match_r6();
      t_valid_r8();
      t_overlap_r9();
      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run incomplete, expected completion");
         finish_run();
      end
   end
endmodule